// File: doc/BRIEF.md
# DDR Burst Column Address Generator

This block produces the column address sequence for a single read or write burst in a double-data-rate SDRAM whose core fetches two data words per internal access. A read or write command loads a starting column, a burst length code, an order select and an auto-precharge request. From the next clock on, the block emits one column pair per cycle. The address shown is that of the first word of each pair, and the pair covers it and the word that follows it in burst order.

Addresses wrap inside an aligned block whose size is the burst length. Only the low bits move, in either linear (sequential) or XOR (interleaved) order, and the bits above the block keep the values given with the command. The final pair carries a last flag. When the command asked for auto-precharge, a precharge request is raised together with that flag. A stop input ends the burst early. A new command restarts the generator at once, even in the middle of a burst. The column width is a parameter: 10, 9 or 8 bits for the three data-width organisations.

Top module: `ddr_col_burst_gen`

## Requirements
- R1: A command (`cmd_valid` high at a rising edge) makes `col_valid` high after that edge, with `col_addr` equal to the loaded `cmd_col`.
- R2: `cmd_bl` encodes the burst length: 0 = 2, 1 = 4, 2 = 8. A burst lasts burst-length/2 cycles, and `col_last` is high exactly on the final one.
- R3: When `cmd_intl` = 0 (sequential), the low log2(BL) bits on pair k equal (start low bits + 2k) modulo BL.
- R4: When `cmd_intl` = 1 (interleaved), the low log2(BL) bits on pair k equal the start low bits XOR 2k. In both orders, the bits above log2(BL) stay equal to the start column.
- R5: Synchronous active-low reset clears `col_valid`, `col_last` and `ap_req`.
- R6: After the last pair, `col_valid` falls on the next cycle unless a new command arrives.
- R7: `ap_req` is high only together with `col_last`, and only when `cmd_ap` was high with the command.
- R8: `burst_stop` high at an edge, with no command at that edge, ends the burst: `col_valid` is low after that edge and no `ap_req` follows. A command at the same edge takes priority over the stop.
- R9: A command that arrives during a burst restarts the sequence from the new column at pair 0.
- R10: Code 3 on `cmd_bl` behaves as burst length 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Read or write command strobe |
| cmd_col | input | COL_W | Starting column |
| cmd_bl | input | 2 | Burst length code |
| cmd_intl | input | 1 | 1 = interleaved order, 0 = sequential |
| cmd_ap | input | 1 | Auto-precharge requested with the command |
| burst_stop | input | 1 | End the current burst |
| col_valid | output | 1 | A column pair is being issued |
| col_addr | output | COL_W | Column of the first word of the current pair |
| col_last | output | 1 | Current pair is the final one |
| ap_req | output | 1 | Start auto-precharge (with the final pair) |

## Verification
All outputs come from registers loaded at the command edge. Pair 0 is therefore due one edge after the command, and pair k is due k edges after that. The bench drives inputs on falling edges and samples on the next falling edge. Each sample it takes sits exactly one rising edge after the stimulus it checks. A stop, a restart or a reset shows its effect at the first sample after the edge that captured it. The check after the final pair confirms that the burst has ended one edge after `col_last`.

// File: rtl/ddr_col_pkg.sv
// Shared definitions for the burst column generator.
// Assumes a two-word prefetch and a largest burst of eight words.
package ddr_col_pkg;
    localparam int MAX_BL = 8;
    localparam int LOW_W  = $clog2(MAX_BL);
    localparam int CNT_W  = LOW_W - 1;

    typedef enum logic [1:0] {
        BLC_2  = 2'd0,
        BLC_4  = 2'd1,
        BLC_8  = 2'd2,
        BLC_8X = 2'd3
    } bl_code_e;

    // Mask of the address bits that wrap for a given burst code.
    function automatic logic [LOW_W-1:0] wrap_mask(input logic [1:0] code);
        case (code)
            BLC_2:   return 3'b001;
            BLC_4:   return 3'b011;
            default: return 3'b111;
        endcase
    endfunction

    // Index of the final pair for a given burst code.
    function automatic logic [CNT_W-1:0] final_pair(input logic [1:0] code);
        case (code)
            BLC_2:   return 2'd0;
            BLC_4:   return 2'd1;
            default: return 2'd3;
        endcase
    endfunction
endpackage

// File: rtl/ddr_col_ctrl.sv
// Burst sequencer: latches the command fields and counts column pairs.
// Assumes a command takes priority over a stop at the same edge.
module ddr_col_ctrl
    import ddr_col_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [COL_W-1:0] cmd_col,
    input  logic [1:0]       cmd_bl,
    input  logic             cmd_intl,
    input  logic             cmd_ap,
    input  logic             burst_stop,
    output logic             active,
    output logic             last,
    output logic [CNT_W-1:0] pair_cnt,
    output logic [COL_W-1:0] start_col,
    output logic [1:0]       bl_q,
    output logic             intl_q,
    output logic             ap_q
);
    // Final pair detection from the running count.
    always_comb last = active && (pair_cnt == final_pair(bl_q));

    // Load on command, advance per cycle, stop on last pair or stop input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            pair_cnt  <= '0;
            start_col <= '0;
            bl_q      <= 2'd0;
            intl_q    <= 1'b0;
            ap_q      <= 1'b0;
        end else if (cmd_valid) begin
            active    <= 1'b1;
            pair_cnt  <= '0;
            start_col <= cmd_col;
            bl_q      <= cmd_bl;
            intl_q    <= cmd_intl;
            ap_q      <= cmd_ap;
        end else if (active) begin
            if (burst_stop || last) active <= 1'b0;
            else                    pair_cnt <= pair_cnt + 1'b1;
        end
    end

    // R2: the count never passes the final pair of the latched length.
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (pair_cnt <= final_pair(bl_q)));
endmodule

// File: rtl/ddr_col_order.sv
// Address former: wraps the low bits of the start column inside the burst block.
// Assumes COL_W is at least the width of the largest burst block.
module ddr_col_order
    import ddr_col_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] start_col,
    input  logic [1:0]       bl_q,
    input  logic             intl_q,
    input  logic [CNT_W-1:0] pair_cnt,
    output logic [COL_W-1:0] col_addr
);
    logic [LOW_W-1:0] step;
    logic [LOW_W-1:0] mask;
    logic [LOW_W-1:0] low_in;
    logic [LOW_W-1:0] low_nx;

    // Pair step, wrap mask and the new low bits in the selected order.
    always_comb begin
        step   = {pair_cnt, 1'b0};
        mask   = wrap_mask(bl_q);
        low_in = start_col[LOW_W-1:0];
        low_nx = intl_q ? (low_in ^ step) : (low_in + step);
        col_addr = start_col;
        col_addr[LOW_W-1:0] = (low_in & ~mask) | (low_nx & mask);
    end
endmodule

// File: rtl/ddr_col_burst_gen.sv
// Top of the burst column generator: one column pair per clock for a
// read or write burst, with last flag and auto-precharge request.
// Assumes outputs are consumed in the cycle they are shown.
module ddr_col_burst_gen
    import ddr_col_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [COL_W-1:0] cmd_col,
    input  logic [1:0]       cmd_bl,
    input  logic             cmd_intl,
    input  logic             cmd_ap,
    input  logic             burst_stop,
    output logic             col_valid,
    output logic [COL_W-1:0] col_addr,
    output logic             col_last,
    output logic             ap_req
);
    logic             active;
    logic             last;
    logic [CNT_W-1:0] pair_cnt;
    logic [COL_W-1:0] start_col;
    logic [1:0]       bl_q;
    logic             intl_q;
    logic             ap_q;

    ddr_col_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_col(cmd_col),
        .cmd_bl(cmd_bl), .cmd_intl(cmd_intl), .cmd_ap(cmd_ap),
        .burst_stop(burst_stop), .active(active), .last(last),
        .pair_cnt(pair_cnt), .start_col(start_col), .bl_q(bl_q),
        .intl_q(intl_q), .ap_q(ap_q)
    );

    ddr_col_order #(.COL_W(COL_W)) u_order (
        .start_col(start_col), .bl_q(bl_q), .intl_q(intl_q),
        .pair_cnt(pair_cnt), .col_addr(col_addr)
    );

    // Output flags from the sequencer state.
    always_comb begin
        col_valid = active;
        col_last  = last;
        ap_req    = last && ap_q;
    end

    // R1: a command yields its start column on the next cycle.
    a_r1_cmd_start: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> (col_valid && col_addr == $past(cmd_col)));

    // R4: bits above the largest block do not move within a burst.
    a_r4_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && $past(col_valid) && !$past(cmd_valid))
        |-> (col_addr[COL_W-1:LOW_W] == $past(col_addr[COL_W-1:LOW_W])));

    // R6: the burst ends after the last pair.
    a_r6_end_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (col_last && !cmd_valid) |=> !col_valid);

    // R7: precharge request only with the last pair.
    a_r7_ap_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        ap_req |-> col_last);

    // R8: a stop without a command ends the burst.
    a_r8_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_stop && !cmd_valid) |=> !col_valid);
endmodule

// File: tb/sim_ddr_col_burst_gen.sv
module sim_ddr_col_burst_gen;
    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic [COL_W-1:0] cmd_col = '0;
    logic [1:0]       cmd_bl = 2'd0;
    logic             cmd_intl = 1'b0;
    logic             cmd_ap = 1'b0;
    logic             burst_stop = 1'b0;
    logic             col_valid;
    logic [COL_W-1:0] col_addr;
    logic             col_last;
    logic             ap_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ddr_col_burst_gen #(.COL_W(COL_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_col(cmd_col),
        .cmd_bl(cmd_bl), .cmd_intl(cmd_intl), .cmd_ap(cmd_ap),
        .burst_stop(burst_stop), .col_valid(col_valid), .col_addr(col_addr),
        .col_last(col_last), .ap_req(ap_req)
    );

    // Stimulus and expected final address: col, bl code, intl, ap, last addr.
    localparam logic [23:0] VECS [0:6] = '{
        {10'h005, 2'd1, 1'b0, 1'b1, 10'h007},
        {10'h006, 2'd2, 1'b1, 1'b0, 10'h000},
        {10'h00E, 2'd2, 1'b0, 1'b1, 10'h00C},
        {10'h3FF, 2'd0, 1'b0, 1'b0, 10'h3FF},
        {10'h2A3, 2'd2, 1'b1, 1'b1, 10'h2A5},
        {10'h1F5, 2'd1, 1'b0, 1'b0, 10'h1F7},
        {10'h0B3, 2'd3, 1'b0, 1'b1, 10'h0B1}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int bl_words(input logic [1:0] code);
        return (code == 2'd0) ? 2 : (code == 2'd1) ? 4 : 8;
    endfunction

    function automatic int exp_addr(input int col, input logic [1:0] code,
                                    input bit il, input int k);
        int sz = bl_words(code);
        int off = col % sz;
        int o = il ? (off ^ (2 * k)) : ((off + 2 * k) % sz);
        return (col - off) + o;
    endfunction

    task automatic issue(input int col, input logic [1:0] code, input bit il, input bit ap);
        cmd_valid = 1'b1; cmd_col = col[COL_W-1:0]; cmd_bl = code;
        cmd_intl = il; cmd_ap = ap;
    endtask

    // Full burst from issue to end, checked pair by pair.
    task automatic run_burst(input int col, input logic [1:0] code, input bit il,
                             input bit ap, input int last_exp);
        int beats = bl_words(code) / 2;
        @(negedge clk); issue(col, code, il, ap);
        for (int k = 0; k < beats; k++) begin
            @(negedge clk); cmd_valid = 1'b0;
            chk(col_valid == 1'b1, "R1", col_valid, 1);
            chk(col_addr == exp_addr(col, code, il, k)[COL_W-1:0],
                il ? "R4" : "R3", col_addr, exp_addr(col, code, il, k));
            chk(col_last == (k == beats - 1), "R2", col_last, k == beats - 1);
            chk(ap_req == (ap && k == beats - 1), "R7", ap_req, ap && k == beats - 1);
            if (k == beats - 1) chk(col_addr == last_exp[COL_W-1:0],
                                    code == 2'd3 ? "R10" : "R2", col_addr, last_exp);
        end
        @(negedge clk);
        chk(col_valid == 1'b0, "R6", col_valid, 0);
    endtask

    initial begin : watchdog
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(col_valid == 1'b0, "R5", col_valid, 0);
        chk(col_last == 1'b0, "R5", col_last, 0);
        chk(ap_req == 1'b0, "R5", ap_req, 0);
        rst_n = 1'b1;

        for (int v = 0; v < 7; v++)
            run_burst(int'(VECS[v][23:14]), VECS[v][13:12], VECS[v][11],
                      VECS[v][10], int'(VECS[v][9:0]));

        // R8: stop during a burst of eight with precharge requested.
        @(negedge clk); issue(16, 2'd2, 1'b0, 1'b1);
        @(negedge clk); cmd_valid = 1'b0; burst_stop = 1'b1;
        chk(col_addr == 10'h010, "R8", col_addr, 10'h010);
        @(negedge clk); burst_stop = 1'b0;
        chk(col_valid == 1'b0, "R8", col_valid, 0);
        chk(ap_req == 1'b0, "R8", ap_req, 0);
        @(negedge clk);
        chk(col_valid == 1'b0, "R8", col_valid, 0);

        // R8: a command at the stop edge wins.
        issue(16, 2'd2, 1'b0, 1'b0);
        @(negedge clk); issue(32, 2'd1, 1'b0, 1'b0); burst_stop = 1'b1;
        @(negedge clk); cmd_valid = 1'b0; burst_stop = 1'b0;
        chk(col_valid == 1'b1 && col_addr == 10'h020, "R8", col_addr, 10'h020);
        @(negedge clk);
        chk(col_addr == 10'h022 && col_last, "R8", col_addr, 10'h022);

        // R9: restart mid-burst from a new column.
        @(negedge clk); issue(256, 2'd2, 1'b0, 1'b0);
        @(negedge clk); issue(10'h203, 2'd1, 1'b1, 1'b1);
        @(negedge clk); cmd_valid = 1'b0;
        chk(col_addr == 10'h203 && !col_last, "R9", col_addr, 10'h203);
        @(negedge clk);
        chk(col_addr == 10'h201, "R9", col_addr, 10'h201);
        chk(col_last && ap_req, "R9", {col_last, ap_req}, 3);
        @(negedge clk);
        chk(col_valid == 1'b0, "R6", col_valid, 0);

        // R5: reset in mid-burst clears the outputs.
        issue(10'h040, 2'd2, 1'b1, 1'b1);
        @(negedge clk); cmd_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk(!col_valid && !col_last && !ap_req, "R5",
            {col_valid, col_last, ap_req}, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule